// File: doc/BRIEF.md
# Programmable Clock Divider Bank

This block runs on one fast reference clock and produces single-cycle clock-enable strobes for four derived domains: a system domain, a memory domain, an output domain and a secondary peripheral domain. The system, memory and output dividers count reference cycles. The peripheral divider counts only system enables, so its rate is a fraction of the system rate. The outputs are enables that the logic of each domain qualifies with, not gated clocks.

A 32-bit control word is written with a one-cycle write strobe. It holds four divisor fields and a command bit. A divisor written on its own is held as pending. Each divider picks it up when it next reaches terminal count, so no period is cut short or stretched. When the command bit is set in a write, every counter reloads on that same edge from the written divisors, and the strobes restart in a common phase. This works even when the divisors do not change.

Top module: `clk_div_bank`

## Requirements
- R1: The system divisor is bits 12:8 of the control word. A value of 1 to 31 gives one `en_sys` pulse every that many reference cycles, and 0 gives one every 32 cycles.
- R2: The memory divisor is bits 20:16 of the control word. A value of 1 to 31 gives one `en_mem` pulse every that many reference cycles, and 0 gives one every 32 cycles.
- R3: The output divisor is bits 28:22 of the control word. A value of 1 to 127 gives one `en_out` pulse every that many reference cycles, and 0 gives one every 128 cycles.
- R4: The peripheral divisor is bits 15:13 of the control word. A value of 1 to 7 gives one `en_per` pulse every that many `en_sys` pulses, and 0 gives one every 8. `en_per` is only ever high in a cycle where `en_sys` is high.
- R5: Every enable is high for exactly one reference cycle per period when its divisor is 2 or more. It is high in every cycle when the divisor is 1.
- R6: A write with bit 29 set reloads all four counters on the write edge from the written divisors. Counting the cycle after the write edge as cycle 1, each of `en_sys`, `en_mem` and `en_out` is first high in the cycle numbered by its divisor. `en_per` is first high in the cycle numbered by the system divisor times the peripheral divisor.
- R7: A write with bit 29 clear does not disturb the running periods. If the write edge is the reload edge right after an `en_sys` pulse, the next `en_sys` still comes after the old divisor, and the new divisor governs the period after that.
- R8: `cfg_rdata` returns the four stored divisor fields in their bit positions. Bit 29 and every bit outside the fields read as 0.
- R9: A synchronous reset clears all stored fields, so `cfg_rdata` reads 0 and every divider is at its largest divisor with the counters in a common phase. The first `en_sys` comes in cycle 32 after the last reset edge.
- R10: A write with bit 29 set and divisor fields equal to those already stored brings all counters back into a common phase. With equal system, memory and output divisors and a peripheral divisor of 1, all four enables are then high in exactly the same cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word: divisor fields and the align command bit 29 |
| cfg_rdata | output | 32 | Stored divisor fields, with the command bit reading 0 |
| en_sys | output | 1 | System domain clock enable |
| en_mem | output | 1 | Memory domain clock enable |
| en_out | output | 1 | Output domain clock enable |
| en_per | output | 1 | Peripheral domain clock enable, a subset of `en_sys` |

## Verification
The bench works through a set of divisor combinations. Each combination is loaded with an aligning write, and for every output both the latency to the first pulse and the following period are measured. The combinations cover all-ones, all-zero fields, all-maximum fields and mixed values, so they separate the zero-means-largest decode from a plain count. They also show a 1-cycle divisor holding its enable high, and show whether the peripheral output tracks the system rate or the reference. Directed cases check the reset latency and the readback masking. They also cover a divisor written exactly on a reload edge, which must keep the old period once, and a re-alignment with unchanged fields, after which all four strobes must match cycle for cycle.

// File: rtl/clk_div_pkg.sv
package clk_div_pkg;

    localparam int SYS_W = 5;
    localparam int MEM_W = 5;
    localparam int OUT_W = 7;
    localparam int PER_W = 3;

    localparam int SYS_LSB = 8;
    localparam int PER_LSB = 13;
    localparam int MEM_LSB = 16;
    localparam int OUT_LSB = 22;
    localparam int ALIGN_BIT = 29;

    typedef struct packed {
        logic [OUT_W-1:0] out_div;
        logic [MEM_W-1:0] mem_div;
        logic [PER_W-1:0] per_div;
        logic [SYS_W-1:0] sys_div;
    } div_cfg_t;

    function automatic div_cfg_t cfg_unpack(input logic [31:0] w);
        div_cfg_t c;
        c.sys_div = w[SYS_LSB +: SYS_W];
        c.per_div = w[PER_LSB +: PER_W];
        c.mem_div = w[MEM_LSB +: MEM_W];
        c.out_div = w[OUT_LSB +: OUT_W];
        return c;
    endfunction

    function automatic logic [31:0] cfg_pack(input div_cfg_t c);
        logic [31:0] w;
        w = '0;
        w[SYS_LSB +: SYS_W] = c.sys_div;
        w[PER_LSB +: PER_W] = c.per_div;
        w[MEM_LSB +: MEM_W] = c.mem_div;
        w[OUT_LSB +: OUT_W] = c.out_div;
        return w;
    endfunction

endpackage

// File: rtl/clk_div_stage.sv
module clk_div_stage #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         align,
    input  logic         tick,
    input  logic [W-1:0] run_div,
    input  logic [W-1:0] align_div,
    output logic         en
);
    // A zero field wraps to all ones on subtraction, which is the largest divisor minus one.
    logic [W-1:0] cnt;
    logic [W-1:0] run_reload;
    logic [W-1:0] align_reload;

    assign run_reload   = run_div - 1'b1;
    assign align_reload = align_div - 1'b1;
    assign en           = tick && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '1;
        end else if (align) begin
            cnt <= align_reload;
        end else if (tick) begin
            cnt <= (cnt == '0) ? run_reload : cnt - 1'b1;
        end
    end

    // R5: a strobe only appears on a counting cycle
    a_r5_en_needs_tick: assert property (@(posedge clk) disable iff (rst)
        en |-> tick);

    // R6: after an align to a divisor above 1 the strobe is low for the next cycle
    a_r6_align_quiet: assert property (@(posedge clk) disable iff (rst)
        (align && align_div != 1) |=> !en);

    // R7: without a tick or an align the phase is held
    a_r7_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!tick && !align) |=> $stable(cnt));

endmodule

// File: rtl/clk_div_bank.sv
module clk_div_bank
    import clk_div_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    output logic        en_sys,
    output logic        en_mem,
    output logic        en_out,
    output logic        en_per
);
    div_cfg_t cfg_q;
    div_cfg_t cfg_new;
    logic     align;

    assign cfg_new   = cfg_unpack(cfg_wdata);
    assign align     = cfg_we && cfg_wdata[ALIGN_BIT];
    assign cfg_rdata = cfg_pack(cfg_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (cfg_we) begin
            cfg_q <= cfg_new;
        end
    end

    clk_div_stage #(.W(SYS_W)) u_sys (
        .clk(clk), .rst(rst), .align(align), .tick(1'b1),
        .run_div(cfg_q.sys_div), .align_div(cfg_new.sys_div), .en(en_sys)
    );

    clk_div_stage #(.W(MEM_W)) u_mem (
        .clk(clk), .rst(rst), .align(align), .tick(1'b1),
        .run_div(cfg_q.mem_div), .align_div(cfg_new.mem_div), .en(en_mem)
    );

    clk_div_stage #(.W(OUT_W)) u_out (
        .clk(clk), .rst(rst), .align(align), .tick(1'b1),
        .run_div(cfg_q.out_div), .align_div(cfg_new.out_div), .en(en_out)
    );

    // Peripheral divider is cascaded: it advances only on system strobes.
    clk_div_stage #(.W(PER_W)) u_per (
        .clk(clk), .rst(rst), .align(align), .tick(en_sys),
        .run_div(cfg_q.per_div), .align_div(cfg_new.per_div), .en(en_per)
    );

    // R4: peripheral strobe is a subset of the system strobe
    a_r4_per_in_sys: assert property (@(posedge clk) disable iff (rst)
        en_per |-> en_sys);

    // R8: the command bit never reads back as set
    a_r8_align_reads_zero: assert property (@(posedge clk) disable iff (rst)
        !cfg_rdata[ALIGN_BIT]);

    // R8: a write is visible on the readback on the following cycle
    a_r8_readback: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> cfg_rdata[SYS_LSB +: SYS_W] == $past(cfg_wdata[SYS_LSB +: SYS_W]));

endmodule

// File: tb/test_clk_div_bank.sv
module test_clk_div_bank;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        en_sys, en_mem, en_out, en_per;
    logic [3:0]  en_v;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    clk_div_bank i_clk_div_bank (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .en_sys(en_sys), .en_mem(en_mem),
        .en_out(en_out), .en_per(en_per)
    );

    assign en_v = {en_per, en_out, en_mem, en_sys};

    // Each vector: system, memory, output, peripheral field values.
    typedef struct packed {
        logic [4:0] s;
        logic [4:0] m;
        logic [6:0] o;
        logic [2:0] p;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{5'd1,  5'd1,  7'd1,   3'd1},
        '{5'd0,  5'd0,  7'd0,   3'd0},
        '{5'd31, 5'd31, 7'd127, 3'd7},
        '{5'd3,  5'd7,  7'd64,  3'd2},
        '{5'd2,  5'd17, 7'd5,   3'd0},
        '{5'd9,  5'd0,  7'd1,   3'd3}
    };

    function automatic logic [31:0] mkw(input int s, input int m, input int o,
                                         input int p, input bit al);
        logic [31:0] w;
        w = '0;
        w[12:8]  = s[4:0];
        w[15:13] = p[2:0];
        w[20:16] = m[4:0];
        w[28:22] = o[6:0];
        w[29]    = al;
        return w;
    endfunction

    function automatic int dv(input int f, input int full);
        return (f == 0) ? full : f;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Called at a negedge; the write edge is the next posedge; returns at the following negedge.
    task automatic wr(input logic [31:0] w);
        cfg_we = 1'b1;
        cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
        cfg_wdata = '0;
    endtask

    // Current negedge counts as 1; returns the count at which the strobe is seen.
    task automatic wait_en(input int idx, output int n);
        n = 1;
        while (!en_v[idx] && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 200000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected below %0d", cyc, 200000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        int exp_d [4];
        string tags [4];
        tags[0] = "R1"; tags[1] = "R2"; tags[2] = "R3"; tags[3] = "R4";

        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 rdata after reset", int'(cfg_rdata), 0);
        rst = 1'b0;
        wait_en(0, n);
        check("R9 first en_sys after reset", n, 32);

        // R6 and R1..R4, R5: table walk
        for (int v = 0; v < NV; v++) begin
            exp_d[0] = dv(VECS[v].s, 32);
            exp_d[1] = dv(VECS[v].m, 32);
            exp_d[2] = dv(VECS[v].o, 128);
            exp_d[3] = dv(VECS[v].s, 32) * dv(VECS[v].p, 8);
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                wr(mkw(VECS[v].s, VECS[v].m, VECS[v].o, VECS[v].p, 1'b1));
                wait_en(k, n);
                check({tags[k], " R6 first pulse after align"}, n, exp_d[k]);
                @(negedge clk);
                wait_en(k, n);
                check({tags[k], " R5 period"}, n, exp_d[k]);
                if (k == 3) check("R4 en_per with en_sys", int'(en_sys), 1);
            end
        end

        // R8: readback masks the command bit and unused bits
        @(negedge clk);
        wr(mkw(5, 11, 100, 6, 1'b1) | 32'hC000_00FF);
        check("R8 readback", int'(cfg_rdata), int'(mkw(5, 11, 100, 6, 1'b0)));

        // R7: divisor written on the reload edge keeps the old period once
        @(negedge clk);
        wr(mkw(4, 4, 4, 1, 1'b1));
        wait_en(0, n);
        wr(mkw(10, 4, 4, 1, 1'b0));
        wait_en(0, n);
        check("R7 old period kept", n, 4);
        @(negedge clk);
        wait_en(0, n);
        check("R7 new period applied", n, 10);

        // R10: skew the phases, then align with unchanged fields
        wr(mkw(5, 3, 7, 2, 1'b0));
        repeat (300) @(negedge clk);
        wr(mkw(5, 5, 5, 1, 1'b0));
        repeat (300) @(negedge clk);
        wr(mkw(5, 5, 5, 1, 1'b1));
        begin
            int mism = 0;
            int pulses = 0;
            for (int c = 0; c < 40; c++) begin
                if (!(en_sys == en_mem && en_sys == en_out && en_sys == en_per)) mism++;
                if (en_sys) pulses++;
                @(negedge clk);
            end
            check("R10 strobes coincide", mism, 0);
            check("R10 pulse count", pulses, 8);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule